// File: doc/BRIEF.md
# Truth-Table Chip Sweep Tester

This block checks a small combinational logic chip wired to a 16-pin drive bus and a narrow sense bus. After a start pulse it steps a pattern index upward from zero through every input combination of the selected device profile. For each index it drives the chip's input pins and waits a programmable settle time. It then samples the chip's outputs and compares them with an expected word held in an on-chip table. That table is filled at elaboration from the profile's logic function.

Two profiles are selected by a parameter:
- **Profile 0**: a quad two-input NAND.
- **Profile 1**: a 3-to-8 line decoder with two active-low enables and one active-high enable.

For the decoder, only five of its eight outputs can be seen, so only those five are compared. When the sweep ends the block raises a done flag and a pass flag. It keeps a count of failing patterns and holds the index, observed word and expected word of the lowest failing pattern.

Top module: `chip_sweep_tester`

## Requirements
- R1: After reset, `done`, `pass`, `mismatch_count`, `fail_index`, `fail_observed`, `fail_expected` and `pin_drive` are all zero.
- R2: NAND profile drive map: chip pin k is `pin_drive[k-1]`. Index bits i0..i3 drive pins 1, 2, 4 and 5, and are repeated on pins 9, 10, 12 and 13. Every other drive bit is 0. There are 16 patterns.
- R3: NAND profile compare map: `sense[3:0]` carries pins {11, 8, 6, 3}. The expected values are pin3 = NOT(i0 AND i1), pin6 = NOT(i2 AND i3), pin8 = pin3 and pin11 = pin6.
- R4: Decoder profile drive map: index bits i0..i2 drive address pins 1 to 3. Bit i3 drives the first active-low enable (pin 4), i4 the second active-low enable (pin 5), and i5 the active-high enable (pin 6). Other drive bits are 0. There are 64 patterns.
- R5: Decoder profile compare map: `sense[k]` is active-low output k, for k = 0..4 only. The expected value is 0 exactly when i5=1, i4=0, i3=0 and i[2:0] = k; otherwise it is 1.
- R6: Let S be the clock edge that samples `start`. Pattern n appears on `pin_drive` at edge S+n·P+1, where P = `settle_cycles`+2. The `sense` value present just before edge S+(n+1)·P is the one compared.
- R7: `done` rises at edge S+N·P, where N is the pattern count. It then holds until the next start.
- R8: `pass` is 1 only while `done` is 1 and no pattern mismatched.
- R9: `mismatch_count` equals the number of patterns whose sampled word differs from the expected word. The `fail_*` outputs hold the lowest failing index with its observed and expected words, and stay zero if nothing failed.
- R10: A start pulse, including one in mid-sweep, clears `done`, `pass`, the count and the `fail_*` outputs. The sweep then restarts from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that (re)starts the sweep |
| settle_cycles | input | SETTLE_W (8) | Extra wait cycles before each sample |
| pin_drive | output | 16 | Registered levels for chip pins 1..16 |
| sense | input | CMP_W (4 for NAND, 5 for decoder) | Observed chip outputs in compare order |
| done | output | 1 | Sweep finished |
| pass | output | 1 | Sweep finished with no mismatch |
| mismatch_count | output | IDX_W+1 (5) | Number of failing patterns |
| fail_index | output | IDX_W (4) | Lowest failing pattern index |
| fail_observed | output | CMP_W (4) | Sampled word of that pattern |
| fail_expected | output | CMP_W (4) | Table word of that pattern |

## Verification
Each pattern costs settle_cycles+2 clocks. The drive register settles one edge after the index moves, and the comparison edge comes settle_cycles+1 edges later. `done` therefore rises exactly N·(settle_cycles+2) edges after the start edge.

The bench counts edges from the start edge and checks each pattern's drive word just after the edge on which it appears. It checks `done` one edge before its due edge and again right after it.

The chip model delays its response by a chosen number of clocks. With a settle time one cycle short, every comparison sees the previous pattern's response. The bench computes that stale count and the first stale failure arithmetically.

// File: rtl/chip_tester_pkg.sv
package chip_tester_pkg;

  localparam int NPINS = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DONE
  } seq_state_t;

  function automatic int idx_width(input int profile);
    return (profile == 0) ? 4 : 6;
  endfunction

  function automatic int cmp_width(input int profile);
    return (profile == 0) ? 4 : 5;
  endfunction

  // Expected compare word for one pattern index (low bits used).
  function automatic logic [7:0] expect_word(input int profile, input int idx);
    logic [7:0] b;
    logic [7:0] r;
    logic       en;
    b = 8'(idx);
    r = '0;
    if (profile == 0) begin
      r[0] = ~(b[0] & b[1]);
      r[1] = ~(b[2] & b[3]);
      r[2] = r[0];
      r[3] = r[1];
    end else begin
      en = b[5] & ~b[4] & ~b[3];
      for (int k = 0; k < 5; k++) begin
        r[k] = ~(en && (b[2:0] == 3'(k)));
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ct_pin_drive.sv
module ct_pin_drive #(
  parameter int PROFILE = 0,
  parameter int IDX_W   = 4,
  parameter int NPINS   = 16
) (
  input  logic [IDX_W-1:0] pattern,
  output logic [NPINS-1:0] pins
);

  generate
    if (PROFILE == 0) begin : g_nand
      always_comb begin
        pins     = '0;
        pins[0]  = pattern[0];
        pins[1]  = pattern[1];
        pins[3]  = pattern[2];
        pins[4]  = pattern[3];
        pins[8]  = pattern[0];
        pins[9]  = pattern[1];
        pins[11] = pattern[2];
        pins[12] = pattern[3];
      end
    end else begin : g_decoder
      always_comb begin
        pins      = '0;
        pins[5:0] = pattern[5:0];
      end
    end
  endgenerate

endmodule

// File: rtl/ct_tt_rom.sv
module ct_tt_rom #(
  parameter int PROFILE = 0,
  parameter int IDX_W   = 4,
  parameter int CMP_W   = 4
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] addr,
  output logic [CMP_W-1:0] data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [CMP_W-1:0] mem [DEPTH];

  initial begin
    logic [7:0] w;
    for (int i = 0; i < DEPTH; i++) begin
      w      = chip_tester_pkg::expect_word(PROFILE, i);
      mem[i] = w[CMP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    data <= mem[addr];
  end

endmodule

// File: rtl/ct_result.sv
module ct_result #(
  parameter int IDX_W = 4,
  parameter int CMP_W = 4,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic [IDX_W-1:0] idx,
  input  logic [CMP_W-1:0] observed,
  input  logic [CMP_W-1:0] expected,
  output logic             hit,
  output logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] fail_idx,
  output logic [CMP_W-1:0] fail_obs,
  output logic [CMP_W-1:0] fail_exp
);

  logic seen;

  assign hit = sample && (observed != expected);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt      <= '0;
      seen     <= 1'b0;
      fail_idx <= '0;
      fail_obs <= '0;
      fail_exp <= '0;
    end else if (hit) begin
      cnt <= cnt + 1'b1;
      if (!seen) begin
        seen     <= 1'b1;
        fail_idx <= idx;
        fail_obs <= observed;
        fail_exp <= expected;
      end
    end
  end

  // R9: the count only grows between clears
  a_r9_count_monotone: assert property (@(posedge clk) disable iff (rst)
    !clear |=> cnt >= $past(cnt));

  // R9: the first failure record is frozen once taken
  a_r9_first_frozen: assert property (@(posedge clk) disable iff (rst)
    (seen && !clear) |=> ($stable(fail_idx) && $stable(fail_obs) && $stable(fail_exp)));

endmodule

// File: rtl/chip_sweep_tester.sv
module chip_sweep_tester #(
  parameter int PROFILE  = 0,
  parameter int SETTLE_W = 8,
  localparam int IDX_W   = chip_tester_pkg::idx_width(PROFILE),
  localparam int CMP_W   = chip_tester_pkg::cmp_width(PROFILE),
  localparam int CNT_W   = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [15:0]         pin_drive,
  input  logic [CMP_W-1:0]    sense,
  output logic                done,
  output logic                pass,
  output logic [CNT_W-1:0]    mismatch_count,
  output logic [IDX_W-1:0]    fail_index,
  output logic [CMP_W-1:0]    fail_observed,
  output logic [CMP_W-1:0]    fail_expected
);

  import chip_tester_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  seq_state_t          state;
  logic [IDX_W-1:0]    idx;
  logic [SETTLE_W:0]   wait_q;
  logic [SETTLE_W:0]   wait_lim;
  logic                sample_now;
  logic                hit;
  logic [CMP_W-1:0]    exp_word;
  logic [NPINS-1:0]    drive_next;

  assign wait_lim   = (SETTLE_W+1)'(settle_cycles) + 1'b1;
  assign sample_now = (state == ST_SETTLE) && (wait_q == wait_lim);

  ct_pin_drive #(.PROFILE(PROFILE), .IDX_W(IDX_W), .NPINS(NPINS)) u_drive (
    .pattern (idx),
    .pins    (drive_next)
  );

  ct_tt_rom #(.PROFILE(PROFILE), .IDX_W(IDX_W), .CMP_W(CMP_W)) u_rom (
    .clk  (clk),
    .addr (idx),
    .data (exp_word)
  );

  ct_result #(.IDX_W(IDX_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_result (
    .clk      (clk),
    .rst      (rst),
    .clear    (start),
    .sample   (sample_now),
    .idx      (idx),
    .observed (sense),
    .expected (exp_word),
    .hit      (hit),
    .cnt      (mismatch_count),
    .fail_idx (fail_index),
    .fail_obs (fail_observed),
    .fail_exp (fail_expected)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_drive <= '0;
    else     pin_drive <= drive_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      idx    <= '0;
      wait_q <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else if (start) begin
      state  <= ST_SETTLE;
      idx    <= '0;
      wait_q <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else begin
      case (state)
        ST_SETTLE: begin
          if (sample_now) begin
            wait_q <= '0;
            if (idx == LAST_IDX) begin
              state <= ST_DONE;
              done  <= 1'b1;
              pass  <= (mismatch_count == '0) && !hit;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  // R7: done holds until a new start
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R8: pass only with done and a clean count
  a_r8_pass_clean: assert property (@(posedge clk) disable iff (rst)
    pass |-> (done && mismatch_count == '0));

  // R10: a start clears the verdict and the count
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && !pass && mismatch_count == '0));

endmodule

// File: tb/chip_sweep_tester_tb_top.sv
module chip_sweep_tester_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // NAND instance
  logic        start_n = 1'b0;
  logic [7:0]  settle_n = 8'd0;
  logic [15:0] drv_n;
  logic [3:0]  sense_n;
  logic        done_n, pass_n;
  logic [4:0]  cnt_n;
  logic [3:0]  fidx_n, fobs_n, fexp_n;

  // decoder instance
  logic        start_d = 1'b0;
  logic [7:0]  settle_d = 8'd0;
  logic [15:0] drv_d;
  logic [4:0]  sense_d;
  logic        done_d, pass_d;
  logic [6:0]  cnt_d;
  logic [5:0]  fidx_d;
  logic [4:0]  fobs_d, fexp_d;

  chip_sweep_tester #(.PROFILE(0), .SETTLE_W(8)) dut_i (
    .clk(clk), .rst(rst), .start(start_n), .settle_cycles(settle_n),
    .pin_drive(drv_n), .sense(sense_n), .done(done_n), .pass(pass_n),
    .mismatch_count(cnt_n), .fail_index(fidx_n),
    .fail_observed(fobs_n), .fail_expected(fexp_n));

  chip_sweep_tester #(.PROFILE(1), .SETTLE_W(8)) dut_dec_i (
    .clk(clk), .rst(rst), .start(start_d), .settle_cycles(settle_d),
    .pin_drive(drv_d), .sense(sense_d), .done(done_d), .pass(pass_d),
    .mismatch_count(cnt_d), .fail_index(fidx_d),
    .fail_observed(fobs_d), .fail_expected(fexp_d));

  // chip models: response delayed by a chosen number of clocks
  int          dly_n = 0, dly_d = 0;
  logic [3:0]  stuck_n = '0;
  logic [4:0]  stuck_d = '0;
  logic [15:0] pipe_n [4];
  logic [15:0] pipe_d [4];
  logic [15:0] pn, pd;
  logic        en_d;

  always_ff @(posedge clk) begin
    pipe_n[0] <= drv_n;
    pipe_d[0] <= drv_d;
    for (int i = 1; i < 4; i++) begin
      pipe_n[i] <= pipe_n[i-1];
      pipe_d[i] <= pipe_d[i-1];
    end
  end

  always_comb begin
    pn = (dly_n == 0) ? drv_n : pipe_n[dly_n-1];
    pd = (dly_d == 0) ? drv_d : pipe_d[dly_d-1];
    sense_n[0] = ~(pn[0] & pn[1]);
    sense_n[1] = ~(pn[3] & pn[4]);
    sense_n[2] = ~(pn[8] & pn[9]);
    sense_n[3] = ~(pn[11] & pn[12]);
    sense_n = sense_n | stuck_n;
    en_d = pd[5] & ~pd[4] & ~pd[3];
    for (int k = 0; k < 5; k++) sense_d[k] = ~(en_d && (pd[2:0] == 3'(k))) | stuck_d[k];
  end

  // bench reference functions
  function automatic logic [15:0] nand_pins(input int n);
    logic [15:0] p = '0;
    p[0] = n[0]; p[1] = n[1]; p[3] = n[2]; p[4] = n[3];
    p[8] = n[0]; p[9] = n[1]; p[11] = n[2]; p[12] = n[3];
    return p;
  endfunction

  function automatic logic [3:0] nand_exp(input int n);
    logic a = !(n[0] && n[1]);
    logic b = !(n[2] && n[3]);
    return {b, a, b, a};
  endfunction

  function automatic logic [15:0] dec_pins(input int n);
    return {10'd0, 6'(n)};
  endfunction

  function automatic logic [4:0] dec_exp(input int n);
    logic [4:0] r = '1;
    if (n >= 32 && n < 40 && (n % 8) < 5) r[n % 8] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_sweep(input int prof, input int settle);
    int npat = prof ? 64 : 16;
    int per  = settle + 2;
    if (prof != 0) settle_d = 8'(settle); else settle_n = 8'(settle);
    @(negedge clk);
    if (prof != 0) start_d = 1'b1; else start_n = 1'b1;
    @(negedge clk);
    start_d = 1'b0; start_n = 1'b0;
    chk("R10 clear", prof ? {cnt_d, done_d, pass_d} : {cnt_n, done_n, pass_n}, 0);
    for (int n = 0; n < npat; n++) begin
      repeat ((n == 0) ? 1 : per) @(posedge clk);
      #1;
      if (prof != 0) chk("R4 R6 drive", drv_d, dec_pins(n));
      else           chk("R2 R6 drive", drv_n, nand_pins(n));
    end
    repeat (per - 2) @(posedge clk);
    #1 chk("R7 done early", prof ? done_d : done_n, 0);
    @(posedge clk);
    #1 chk("R7 done due", prof ? done_d : done_n, 1);
  endtask

  task automatic check_res(input int prof, input int epass, input int ecnt,
                           input int eidx, input int eobs, input int eexp);
    repeat (3) @(posedge clk);
    #1;
    chk("R7 done held", prof ? done_d : done_n, 1);
    chk("R8 pass", prof ? pass_d : pass_n, epass);
    chk("R9 count", prof ? cnt_d : cnt_n, ecnt);
    chk("R9 first index", prof ? fidx_d : fidx_n, eidx);
    chk(prof ? "R5 R9 observed" : "R3 R9 observed", prof ? fobs_d : fobs_n, eobs);
    chk(prof ? "R5 R9 expected" : "R3 R9 expected", prof ? fexp_d : fexp_n, eexp);
  endtask

  initial begin
    int ecnt, efirst, prv;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 nand state", {drv_n, done_n, pass_n, cnt_n, fidx_n, fobs_n, fexp_n}, 0);
    chk("R1 dec state", {drv_d, done_d, pass_d, cnt_d, fidx_d, fobs_d, fexp_d}, 0);

    // NAND, healthy, settle matches chip delay
    dly_n = 3;
    run_sweep(0, 3);
    check_res(0, 1, 0, 0, 0, 0);

    // NAND, pin 8 stuck high: fails at indices 3,7,11,15
    stuck_n = 4'b0100;
    run_sweep(0, 3);
    check_res(0, 0, 4, 3, 4'hE, 4'hA);

    // R10: restart in mid-sweep after a failure was recorded
    settle_n = 8'd3;
    @(negedge clk) start_n = 1'b1;
    @(negedge clk) start_n = 1'b0;
    repeat (30) @(posedge clk);
    #1 chk("R9 mid-run count", cnt_n, 1);
    stuck_n = '0;
    run_sweep(0, 3);
    check_res(0, 1, 0, 0, 0, 0);

    // R6: settle one cycle short, every sample sees the previous pattern
    ecnt = 0; efirst = -1;
    for (int n = 0; n < 16; n++) begin
      prv = (n == 0) ? 15 : n - 1;
      if (nand_exp(n) != nand_exp(prv)) begin
        ecnt++;
        if (efirst < 0) efirst = n;
      end
    end
    run_sweep(0, 2);
    check_res(0, 0, ecnt, efirst, nand_exp(efirst - 1), nand_exp(efirst));

    // decoder, combinational response, minimum settle
    dly_d = 0;
    run_sweep(1, 0);
    check_res(1, 1, 0, 0, 0, 0);

    // decoder, output 2 stuck high: only index 34 fails
    dly_d = 1;
    stuck_d = 5'b00100;
    run_sweep(1, 1);
    check_res(1, 0, 1, 34, 5'h1F, 5'h1B);
    chk("R5 table", dec_exp(34), 5'h1B);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule